// File: doc/BRIEF.md
# Banked Window Address Translator

This block lets an 8-bit sound processor reach the 24-bit address space of the main processor through a 32 KB window. A bank register holds the upper nine address bits of the window. Software loads it one bit per write: each bank write moves the current contents one place toward the low end, and the new bit enters at the top address bit.

Every window access is combined with the bank base to form a full 24-bit target address. The target is then classified by its top byte into one of five regions. That class decides whether the access goes on to the bus fabric, is dropped, or raises a lockup flag. Read data for dropped or illegal reads is a fixed all-ones byte. Forwarded reads take their data from the fabric.

All access outputs are combinational from the current bank base and the access inputs. Only the bank register is clocked.

Top module: `bank_window_xlate`

## Requirements
- R1: After reset the bank base is 0x000000, so the translated address equals the window offset.
- R2: A bank write moves the stored bits 23..15 down by one place (old bit 23 goes to bit 22, and so on; old bit 15 is lost). It puts `bank_bit` into bit 23 and keeps bits 14..0 at zero. Without a bank write the base holds its value.
- R3: Nine consecutive bank writes fully set the base, whatever its contents were before. The first bit written ends up at address bit 15 and the ninth at bit 23.
- R4: `xl_addr` is the bank base ORed with the 15-bit `acc_offset`.
- R5: Targets 0x000000–0x7FFFFF give region code 0 (external) and are forwarded on read and write.
- R6: Targets with top byte 0xA1 give region code 1 (I/O and control) and are forwarded.
- R7: Targets with top byte 0xC0, 0xC8, 0xD0 or 0xD8 give region code 2 (video ports). They are forwarded and never raise lockup.
- R8: All other targets 0x800000–0xDFFFFF give region code 4 (illegal). They raise `lockup` on both read and write, are not forwarded, and read as 0xFF.
- R9: Targets 0xE00000–0xFFFFFF give region code 3 (work RAM). Writes are forwarded. Reads are not forwarded and return 0xFF.
- R10: A forwarded read returns `fwd_rdata` on `rd_data`.
- R11: With `acc_valid` low, `fwd` and `lockup` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_wr | input | 1 | Bank register write strobe |
| bank_bit | input | 1 | Bit shifted in at address bit 23 |
| acc_valid | input | 1 | Window access present |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_offset | input | 15 | Offset inside the 32 KB window |
| fwd_rdata | input | 8 | Read data returned by the fabric |
| xl_addr | output | 24 | Translated 24-bit target address |
| region | output | 3 | Region code (0 ext, 1 io, 2 video, 3 wram, 4 illegal) |
| fwd | output | 1 | Access is passed on to the fabric |
| lockup | output | 1 | Access hit an illegal target |
| rd_data | output | 8 | Read data to the sound processor |

## Verification
The bench targets the edges of each region. It tests 0x7F8000 against 0x800000, 0xA00000 against 0xA10000, 0xC10000 and 0xDF8000 against the four video pages, and 0xE00000. A design that tested only the top bit of the page would send the illegal pages to external or video. A design that matched 0xC0–0xDF as one block would let 0xC10000 through without lockup.

The bench also tests the asymmetry in work RAM. A design that allowed reads there would return fabric data instead of 0xFF. For the serial load, the bench checks the shift direction after one and after two writes. A design that shifted upward, or let the new bit enter at bit 15, would give the wrong address. Reloading after an all-ones base shows whether any stale bit survives nine writes.

// File: rtl/bank_window_pkg.sv
package bank_window_pkg;

  typedef enum logic [2:0] {
    RGN_EXT   = 3'd0,
    RGN_IO    = 3'd1,
    RGN_VIDEO = 3'd2,
    RGN_WRAM  = 3'd3,
    RGN_ILL   = 3'd4
  } region_e;

  localparam int unsigned PAGE_W = 8;

  localparam logic [PAGE_W-1:0] PG_ILL_LO = 8'h80;
  localparam logic [PAGE_W-1:0] PG_IO     = 8'hA1;
  localparam logic [PAGE_W-1:0] PG_VID_LO = 8'hC0;
  localparam logic [PAGE_W-1:0] PG_WRAM   = 8'hE0;

endpackage

// File: rtl/bank_base_reg.sv
module bank_base_reg #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WIN_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  output logic [ADDR_W-1:0] base
);
  localparam int unsigned KEEP_W = ADDR_W - WIN_W;

  logic [KEEP_W-1:0] kept_q;

  function automatic logic [KEEP_W-1:0] push_top(input logic [KEEP_W-1:0] cur,
                                                 input logic b);
    return {b, cur[KEEP_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        kept_q <= '0;
    else if (shift_en) kept_q <= push_top(kept_q, shift_bit);
  end

  assign base = {kept_q, {WIN_W{1'b0}}};
endmodule

// File: rtl/window_region_decode.sv
module window_region_decode
  import bank_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              valid,
  input  logic              is_write,
  output region_e           region,
  output logic              fwd,
  output logic              lockup
);
  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1 -: PAGE_W];

  function automatic region_e classify(input logic [PAGE_W-1:0] pg);
    if (pg < PG_ILL_LO)                                 return RGN_EXT;
    if (pg >= PG_WRAM)                                  return RGN_WRAM;
    if (pg == PG_IO)                                    return RGN_IO;
    if (pg >= PG_VID_LO && pg[2:0] == 3'b000)           return RGN_VIDEO;
    return RGN_ILL;
  endfunction

  function automatic logic passes(input region_e r, input logic wr);
    case (r)
      RGN_EXT, RGN_IO, RGN_VIDEO: return 1'b1;
      RGN_WRAM:                   return wr;
      default:                    return 1'b0;
    endcase
  endfunction

  assign region = classify(page);
  assign fwd    = valid && passes(region, is_write);
  assign lockup = valid && (region == RGN_ILL);
endmodule

// File: rtl/window_read_mux.sv
module window_read_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              valid,
  input  logic              is_write,
  input  logic              fwd,
  input  logic [DATA_W-1:0] fabric_data,
  output logic [DATA_W-1:0] data_out
);
  logic fwd_read;
  assign fwd_read = valid && !is_write && fwd;
  assign data_out = fwd_read ? fabric_data : {DATA_W{1'b1}};
endmodule

// File: rtl/bank_window_xlate.sv
module bank_window_xlate
  import bank_window_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WIN_W  = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_wr,
  input  logic              bank_bit,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [WIN_W-1:0]  acc_offset,
  input  logic [DATA_W-1:0] fwd_rdata,
  output logic [ADDR_W-1:0] xl_addr,
  output logic [2:0]        region,
  output logic              fwd,
  output logic              lockup,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] bank_base;
  region_e           rgn;

  function automatic logic [ADDR_W-1:0] join_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [WIN_W-1:0] o);
    return b | {{(ADDR_W-WIN_W){1'b0}}, o};
  endfunction

  bank_base_reg #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_base (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (bank_wr),
    .shift_bit (bank_bit),
    .base      (bank_base)
  );

  assign xl_addr = join_addr(bank_base, acc_offset);

  window_region_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (xl_addr),
    .valid    (acc_valid),
    .is_write (acc_write),
    .region   (rgn),
    .fwd      (fwd),
    .lockup   (lockup)
  );

  assign region = rgn;

  window_read_mux #(.DATA_W(DATA_W)) u_rmux (
    .valid       (acc_valid),
    .is_write    (acc_write),
    .fwd         (fwd),
    .fabric_data (fwd_rdata),
    .data_out    (rd_data)
  );
endmodule

// File: rtl/bank_window_xlate_chk.sv
module bank_window_xlate_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned WIN_W  = 15,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bank_wr,
  input logic              bank_bit,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [WIN_W-1:0]  acc_offset,
  input logic [ADDR_W-1:0] bank_base,
  input logic [ADDR_W-1:0] xl_addr,
  input logic [2:0]        region,
  input logic              fwd,
  input logic              lockup,
  input logic [DATA_W-1:0] rd_data
);
  p_shift_in_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> bank_base[ADDR_W-1] == $past(bank_bit) &&
                bank_base[ADDR_W-2:WIN_W] == $past(bank_base[ADDR_W-1:WIN_W+1]));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(bank_base));

  p_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    xl_addr[WIN_W-1:0] == acc_offset);

  p_lock_nofwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lockup |-> !fwd && region == 3'd4 && (acc_write || rd_data == {DATA_W{1'b1}}));

  p_wram_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && region == 3'd3) |-> !fwd && rd_data == {DATA_W{1'b1}});

  p_video_nolock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && region == 3'd2) |-> fwd && !lockup);

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !fwd && !lockup);
endmodule

bind bank_window_xlate bank_window_xlate_chk #(
  .ADDR_W(ADDR_W), .WIN_W(WIN_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_bit(bank_bit),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
  .bank_base(bank_base), .xl_addr(xl_addr), .region(region), .fwd(fwd),
  .lockup(lockup), .rd_data(rd_data)
);

// File: tb/bank_window_xlate_bench.sv
`timescale 1ns/1ps
module bank_window_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_wr = 1'b0, bank_bit = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [14:0] acc_offset = '0;
  logic [7:0]  fwd_rdata = 8'h5A;
  logic [23:0] xl_addr;
  logic [2:0]  region;
  logic        fwd, lockup;
  logic [7:0]  rd_data;

  int total = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_window_xlate u_bank_window_xlate (
    .clk(clk), .rst_n(rst_n), .bank_wr(bank_wr), .bank_bit(bank_bit),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_offset(acc_offset),
    .fwd_rdata(fwd_rdata), .xl_addr(xl_addr), .region(region), .fwd(fwd),
    .lockup(lockup), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bank_write(input logic b);
    @(negedge clk);
    bank_wr = 1'b1; bank_bit = b;
    @(negedge clk);
    bank_wr = 1'b0;
  endtask

  // first written bit lands at address bit 15, ninth at bit 23
  task automatic load_base(input logic [23:0] b);
    for (int i = 15; i < 24; i++) bank_write(b[i]);
  endtask

  task automatic probe(input logic [14:0] off, input logic wr);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_offset = off;
    #1;
  endtask

  // expected region by numeric ranges of the target
  function automatic logic [2:0] exp_region(input logic [23:0] a);
    if (a <= 24'h7FFFFF) return 3'd0;
    if (a >= 24'hE00000) return 3'd3;
    if (a >= 24'hA10000 && a <= 24'hA1FFFF) return 3'd1;
    if (a[23:16] == 8'hC0 || a[23:16] == 8'hC8 ||
        a[23:16] == 8'hD0 || a[23:16] == 8'hD8) return 3'd2;
    return 3'd4;
  endfunction

  task automatic t_reset;
    probe(15'h1234, 1'b0);
    check("R1 addr after reset", xl_addr, 24'h001234);
    check("R5 region after reset", region, 3'd0);
  endtask

  task automatic t_shift_partial;
    bank_write(1'b1);
    probe(15'h0000, 1'b0);
    check("R2 one write", xl_addr, 24'h800000);
    bank_write(1'b0);
    probe(15'h0000, 1'b0);
    check("R2 two writes", xl_addr, 24'h400000);
    acc_valid = 1'b0;
    repeat (3) @(negedge clk);
    probe(15'h0000, 1'b0);
    check("R2 hold without write", xl_addr, 24'h400000);
  endtask

  task automatic t_full_load;
    load_base(24'hFF8000);
    probe(15'h7FFF, 1'b1);
    check("R3 all ones", xl_addr, 24'hFFFFFF);
    load_base(24'h0A8000);
    probe(15'h0123, 1'b0);
    check("R3 R4 reload", xl_addr, 24'h0A8123);
  endtask

  task automatic t_region(input logic [23:0] b, input logic [14:0] off, input logic wr);
    logic [23:0] a;
    logic [2:0]  r;
    logic        f, l;
    a = b | {9'd0, off};
    r = exp_region(a);
    l = (r == 3'd4);
    f = (r <= 3'd2) || (r == 3'd3 && wr);
    load_base(b);
    probe(off, wr);
    check($sformatf("R4 addr %h", a), xl_addr, a);
    check($sformatf("R5 R6 R7 R8 R9 region %h", a), region, r);
    check($sformatf("R8 R9 fwd %h wr%0d", a, wr), fwd, f);
    check($sformatf("R8 lockup %h wr%0d", a, wr), lockup, l);
    if (!wr) check($sformatf("R10 rdata %h", a), rd_data, f ? 8'h5A : 8'hFF);
  endtask

  task automatic t_idle;
    load_base(24'h808000);
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; #1;
    check("R11 idle lockup", lockup, 1'b0);
    check("R11 idle fwd", fwd, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_shift_partial();
    t_full_load();
    t_region(24'h7F8000, 15'h0010, 1'b0);
    t_region(24'h800000, 15'h0000, 1'b0);
    t_region(24'h800000, 15'h0000, 1'b1);
    t_region(24'hA00000, 15'h0001, 1'b0);
    t_region(24'hA10000, 15'h000C, 1'b0);
    t_region(24'hA10000, 15'h000C, 1'b1);
    t_region(24'hC00000, 15'h0004, 1'b0);
    t_region(24'hC10000, 15'h0004, 1'b1);
    t_region(24'hC80000, 15'h0000, 1'b1);
    t_region(24'hD00000, 15'h0000, 1'b0);
    t_region(24'hD80000, 15'h0008, 1'b1);
    t_region(24'hDF8000, 15'h7FFF, 1'b0);
    t_region(24'hE00000, 15'h0000, 1'b0);
    t_region(24'hE00000, 15'h0000, 1'b1);
    t_region(24'hFF8000, 15'h7FFE, 1'b0);
    t_idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule